// File: doc/BRIEF.md
# Multiplexed Bus Cycle Demultiplexer

This block sits next to a processor whose address and data share one 16-bit bus, with a further 4-bit nibble that carries the top address bits early in a cycle and status later. It captures the full 20-bit address while the latch strobe is high and commits it when the strobe falls. It holds that address until the next strobe pulse and turns the latched byte-high enable and address bit 0 into two byte-lane enables.

In parallel it turns the 3-bit bus status code into one-hot command strobes: memory read, memory write, I/O read, I/O write, interrupt acknowledge, code fetch and halt. It drives the transceiver direction and data-enable controls, and it pulls the segment selector and the interrupt-enable flag out of the status nibble. All outputs are registered and change one clock after the inputs that cause them. The bus phase is given by a T-state input: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4. Higher values count as idle.

All pins are plain levels. The block sits on a bus whose timing is fixed by the processor, so it has no valid/ready handshake and applies no back-pressure. Every input is sampled on every clock.

Top module: `bus_demux`

## Requirements
- R1: After reset, addr_o is 0, be_o is 00, and every command strobe, den_o, dtr_o, seg_o and ie_o is 0.
- R2: Each clock with ale_i high stores {ast_i, ad_i} and bhe_n_i. On the first clock with ale_i low, addr_o takes the value stored at the last ale_i-high clock.
- R3: addr_o and be_o do not change while ale_i stays low, whatever ad_i, ast_i and bhe_n_i do.
- R4: be_o[0] enables the low lane and be_o[1] the high lane. They come from the latched (bhe_n, A0) pair: 00 gives 11, 01 gives 10, 10 gives 01, 11 gives 00.
- R5: In a T2–T4 clock, stat_i selects one strobe: 000 inta_o, 001 iord_o, 010 iowr_o, 011 halt_o, 100 fetch_o, 101 mrd_o, 110 mwr_o.
- R6: No command strobe, den_o or dtr_o is asserted for a clock whose tstate_i is idle or T1. Every strobe appears one clock after the T-state that qualifies it.
- R7: Code 111 asserts nothing. Code 011 asserts only halt_o, with den_o and dtr_o low.
- R8: den_o is 1 after a T2–T4 clock whose code is neither 011 nor 111, and 0 otherwise.
- R9: dtr_o is 1 after a T2–T4 clock whose code is a write (010 or 110), and 0 otherwise.
- R10: In a clock with ale_i low and tstate_i in T2–T4, seg_o takes ast_i[1:0] and ie_o takes ast_i[2]. At all other times both hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale_i | input | 1 | Address latch strobe, high during the address phase |
| bhe_n_i | input | 1 | Active-low byte-high enable, latched with the address |
| ad_i | input | 16 | Shared address/data bus |
| ast_i | input | 4 | Upper address bits, or status bits in the data phase |
| stat_i | input | 3 | Bus status code |
| tstate_i | input | 3 | Bus phase: 0 idle, 1..4 T1..T4 |
| addr_o | output | 20 | Latched address |
| be_o | output | 2 | Byte-lane enables, bit 1 high lane |
| mrd_o | output | 1 | Memory read strobe |
| mwr_o | output | 1 | Memory write strobe |
| iord_o | output | 1 | I/O read strobe |
| iowr_o | output | 1 | I/O write strobe |
| inta_o | output | 1 | Interrupt acknowledge strobe |
| fetch_o | output | 1 | Code fetch strobe |
| halt_o | output | 1 | Halt indication |
| dtr_o | output | 1 | Transceiver direction, 1 transmit |
| den_o | output | 1 | Transceiver data enable |
| seg_o | output | 2 | Segment selector from status |
| ie_o | output | 1 | Interrupt-enable flag from status |

## Verification
The bench runs every byte-enable/A0 pairing against all eight status codes. A design that swaps lanes or misreads the 01/10 cases would show the wrong be_o on half of these cycles. It also checks that strobes stay low in T1 and in idle, since a design without T-state gating would strobe early. It checks that halt and passive cycles raise no den_o and no read or write strobe. To catch a transparent latch that follows data-phase traffic, it drives data on the shared bus and rewrites bhe_n_i after ALE falls, then confirms the address holds. A two-clock ALE pulse checks that the last address value wins, and idle-phase status changes check that seg_o and ie_o hold.

// File: rtl/bdmx_pkg.sv
package bdmx_pkg;

  localparam logic [2:0] CODE_INTA    = 3'b000;
  localparam logic [2:0] CODE_IORD    = 3'b001;
  localparam logic [2:0] CODE_IOWR    = 3'b010;
  localparam logic [2:0] CODE_HALT    = 3'b011;
  localparam logic [2:0] CODE_FETCH   = 3'b100;
  localparam logic [2:0] CODE_MRD     = 3'b101;
  localparam logic [2:0] CODE_MWR     = 3'b110;
  localparam logic [2:0] CODE_PASSIVE = 3'b111;

  localparam logic [2:0] TS_T2 = 3'd2;
  localparam logic [2:0] TS_T3 = 3'd3;
  localparam logic [2:0] TS_T4 = 3'd4;

  typedef struct packed {
    logic inta;
    logic iord;
    logic iowr;
    logic halt;
    logic fetch;
    logic mrd;
    logic mwr;
  } cmd_t;

  function automatic logic in_window(input logic [2:0] ts);
    return (ts == TS_T2) || (ts == TS_T3) || (ts == TS_T4);
  endfunction

  function automatic cmd_t decode_code(input logic [2:0] code);
    cmd_t c;
    c = '0;
    case (code)
      CODE_INTA:  c.inta  = 1'b1;
      CODE_IORD:  c.iord  = 1'b1;
      CODE_IOWR:  c.iowr  = 1'b1;
      CODE_HALT:  c.halt  = 1'b1;
      CODE_FETCH: c.fetch = 1'b1;
      CODE_MRD:   c.mrd   = 1'b1;
      CODE_MWR:   c.mwr   = 1'b1;
      default:    c       = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bdmx_addr_latch.sv
module bdmx_addr_latch #(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   nib_i,
  input  logic              bhe_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bhe_n_o,
  output logic              vld_o
);

  logic [ADDR_W-1:0] shadow_q;
  logic              shadow_bhe_q;
  logic              ale_d;
  logic [ADDR_W-1:0] addr_q;
  logic              bhe_q;
  logic              vld_q;
  logic              commit;

  assign commit = ale_d && !ale_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q     <= '0;
      shadow_bhe_q <= 1'b1;
      ale_d        <= 1'b0;
      addr_q       <= '0;
      bhe_q        <= 1'b1;
      vld_q        <= 1'b0;
    end else begin
      ale_d <= ale_i;
      if (ale_i) begin
        shadow_q     <= {nib_i, ad_i};
        shadow_bhe_q <= bhe_n_i;
      end
      if (commit) begin
        addr_q <= shadow_q;
        bhe_q  <= shadow_bhe_q;
        vld_q  <= 1'b1;
      end
    end
  end

  assign addr_o  = addr_q;
  assign bhe_n_o = bhe_q;
  assign vld_o   = vld_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_i && !ale_d) |=> $stable(addr_q)) else $error("address moved in data phase"); // R3

endmodule

// File: rtl/bdmx_lane_decode.sv
module bdmx_lane_decode #(
  parameter int LANES = 2
) (
  input  logic             vld_i,
  input  logic             bhe_n_i,
  input  logic             a0_i,
  output logic [LANES-1:0] be_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign be_o[g] = vld_i && !a0_i;
    end else if (g == 1) begin : g_high
      assign be_o[g] = vld_i && !bhe_n_i;
    end else begin : g_none
      assign be_o[g] = 1'b0;
    end
  end

  always_comb begin
    AST_LANE_NONE: assert (!(vld_i && bhe_n_i && a0_i) || (be_o[1:0] == 2'b00)); // R4
  end

endmodule

// File: rtl/bdmx_cmd_decode.sv
module bdmx_cmd_decode
  import bdmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code_i,
  input  logic [2:0] ts_i,
  output cmd_t       cmd_o,
  output logic       den_o,
  output logic       dtr_o
);

  logic win;
  cmd_t cmd_d;
  logic den_d;
  logic dtr_d;
  cmd_t cmd_q;
  logic den_q;
  logic dtr_q;

  always_comb begin
    win   = in_window(ts_i);
    cmd_d = win ? decode_code(code_i) : '0;
    den_d = win && (code_i != CODE_HALT) && (code_i != CODE_PASSIVE);
    dtr_d = win && ((code_i == CODE_IOWR) || (code_i == CODE_MWR));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      den_q <= 1'b0;
      dtr_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      den_q <= den_d;
      dtr_q <= dtr_d;
    end
  end

  assign cmd_o = cmd_q;
  assign den_o = den_q;
  assign dtr_o = dtr_q;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q)) else $error("more than one strobe"); // R5
  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window(ts_i) |=> (cmd_q == '0)) else $error("strobe outside window"); // R6

endmodule

// File: rtl/bdmx_stat_extract.sv
module bdmx_stat_extract
  import bdmx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale_i,
  input  logic [2:0] ts_i,
  input  logic [2:0] stat_bits_i,
  output logic [1:0] seg_o,
  output logic       ie_o
);

  logic       take;
  logic [1:0] seg_q;
  logic       ie_q;

  assign take = !ale_i && in_window(ts_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0;
      ie_q  <= 1'b0;
    end else if (take) begin
      seg_q <= stat_bits_i[1:0];
      ie_q  <= stat_bits_i[2];
    end
  end

  assign seg_o = seg_q;
  assign ie_o  = ie_q;

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(seg_q) && $stable(ie_q))) else $error("status moved"); // R10

endmodule

// File: rtl/bus_demux.sv
module bus_demux
  import bdmx_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 4,
  parameter int LANES = 2,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale_i,
  input  logic              bhe_n_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   ast_i,
  input  logic [2:0]        stat_i,
  input  logic [2:0]        tstate_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic              mrd_o,
  output logic              mwr_o,
  output logic              iord_o,
  output logic              iowr_o,
  output logic              inta_o,
  output logic              fetch_o,
  output logic              halt_o,
  output logic              dtr_o,
  output logic              den_o,
  output logic [1:0]        seg_o,
  output logic              ie_o
);

  logic bhe_l;
  logic addr_vld;
  cmd_t cmd;

  bdmx_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_i   (ale_i),
    .ad_i    (ad_i),
    .nib_i   (ast_i),
    .bhe_n_i (bhe_n_i),
    .addr_o  (addr_o),
    .bhe_n_o (bhe_l),
    .vld_o   (addr_vld)
  );

  bdmx_lane_decode #(.LANES(LANES)) u_lane (
    .vld_i   (addr_vld),
    .bhe_n_i (bhe_l),
    .a0_i    (addr_o[0]),
    .be_o    (be_o)
  );

  bdmx_cmd_decode u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (stat_i),
    .ts_i   (tstate_i),
    .cmd_o  (cmd),
    .den_o  (den_o),
    .dtr_o  (dtr_o)
  );

  bdmx_stat_extract u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .ale_i       (ale_i),
    .ts_i        (tstate_i),
    .stat_bits_i (ast_i[2:0]),
    .seg_o       (seg_o),
    .ie_o        (ie_o)
  );

  assign inta_o  = cmd.inta;
  assign iord_o  = cmd.iord;
  assign iowr_o  = cmd.iowr;
  assign halt_o  = cmd.halt;
  assign fetch_o = cmd.fetch;
  assign mrd_o   = cmd.mrd;
  assign mwr_o   = cmd.mwr;

  AST_XFER_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_o || mwr_o || iord_o || iowr_o || inta_o || fetch_o) |-> den_o) else $error("strobe without den"); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (!den_o && !dtr_o)) else $error("halt drove bus"); // R7
  AST_DTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dtr_o |-> (mwr_o || iowr_o)) else $error("transmit without write"); // R9

endmodule

// File: tb/bus_demux_tb.sv
module bus_demux_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale_i = 1'b0;
  logic        bhe_n_i = 1'b1;
  logic [15:0] ad_i = '0;
  logic [3:0]  ast_i = '0;
  logic [2:0]  stat_i = 3'b111;
  logic [2:0]  tstate_i = 3'd0;
  logic [19:0] addr_o;
  logic [1:0]  be_o;
  logic mrd_o, mwr_o, iord_o, iowr_o, inta_o, fetch_o, halt_o, dtr_o, den_o;
  logic [1:0]  seg_o;
  logic        ie_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bus_demux u_dut (
    .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .bhe_n_i(bhe_n_i), .ad_i(ad_i),
    .ast_i(ast_i), .stat_i(stat_i), .tstate_i(tstate_i), .addr_o(addr_o),
    .be_o(be_o), .mrd_o(mrd_o), .mwr_o(mwr_o), .iord_o(iord_o), .iowr_o(iowr_o),
    .inta_o(inta_o), .fetch_o(fetch_o), .halt_o(halt_o), .dtr_o(dtr_o),
    .den_o(den_o), .seg_o(seg_o), .ie_o(ie_o)
  );

  function automatic logic [6:0] strobes();
    return {inta_o, iord_o, iowr_o, halt_o, fetch_o, mrd_o, mwr_o};
  endfunction

  function automatic logic [6:0] exp_cmd(input logic [2:0] code);
    return (code == 3'b111) ? 7'b0 : (7'b1000000 >> code);
  endfunction

  function automatic logic [1:0] exp_be(input logic bhe, input logic a0);
    return {~bhe, ~a0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ale, input logic bhe, input logic [15:0] ad,
                      input logic [3:0] nib, input logic [2:0] code, input logic [2:0] ts);
    @(negedge clk);
    ale_i = ale; bhe_n_i = bhe; ad_i = ad; ast_i = nib; stat_i = code; tstate_i = ts;
    @(posedge clk);
    #1;
  endtask

  task automatic bus_cycle(input logic [19:0] addr, input logic bhe, input logic [2:0] code,
                           input logic [1:0] seg, input logic ie);
    logic den_e, dtr_e;
    den_e = (code != 3'b011) && (code != 3'b111);
    dtr_e = (code == 3'b010) || (code == 3'b110);
    step(1'b1, bhe, addr[15:0], addr[19:16], code, 3'd1);
    chk("R6 no strobe in T1", {strobes(), den_o, dtr_o}, 9'h0);
    step(1'b0, 1'b1, 16'hD00D, {1'b0, ie, seg}, code, 3'd2);
    chk("R2 address committed", addr_o, addr);
    chk("R4 lanes", be_o, exp_be(bhe, addr[0]));
    chk("R5 R7 strobe T2", strobes(), exp_cmd(code));
    chk("R8 den", den_o, den_e);
    chk("R9 dtr", dtr_o, dtr_e);
    chk("R10 status", {ie_o, seg_o}, {ie, seg});
    step(1'b0, 1'b0, 16'hBEEF, {1'b0, ie, seg}, code, 3'd3);
    chk("R5 strobe T3", strobes(), exp_cmd(code));
    step(1'b0, 1'b1, 16'h1234, {1'b0, ie, seg}, code, 3'd4);
    chk("R5 strobe T4", strobes(), exp_cmd(code));
    chk("R3 lanes held", be_o, exp_be(bhe, addr[0]));
    step(1'b0, ~bhe, 16'hFFFF, 4'hF, 3'b111, 3'd0);
    chk("R6 idle quiet", {strobes(), den_o, dtr_o}, 9'h0);
    chk("R3 address held", addr_o, addr);
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_o, 20'h0);
    chk("R1 be", be_o, 2'b00);
    chk("R1 strobes", {strobes(), den_o, dtr_o}, 9'h0);
    chk("R1 status", {ie_o, seg_o}, 3'b0);
  endtask

  task automatic t_matrix();
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 8; c++)
          bus_cycle({4'(c + 3), 15'(c * 977 + b * 31), a[0]}, b[0], c[2:0], 2'(c), c[0]);
  endtask

  task automatic t_hold();
    bus_cycle(20'hA5C3E, 1'b0, 3'b101, 2'b10, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, i[0], 16'(i * 4099), 4'(i), 3'b111, 3'd0);
      chk("R3 hold under traffic", {addr_o, be_o}, {20'hA5C3E, 2'b11});
    end
    step(1'b1, 1'b1, 16'h1111, 4'h1, 3'b111, 3'd1);
    step(1'b1, 1'b0, 16'h2223, 4'h7, 3'b111, 3'd1);
    chk("R3 held during ALE", addr_o, 20'hA5C3E);
    step(1'b0, 1'b1, 16'h0, 4'h0, 3'b111, 3'd2);
    chk("R2 last ALE value wins", addr_o, 20'h72223);
    chk("R4 odd high byte", be_o, 2'b10);
    chk("R7 passive quiet", {strobes(), den_o, dtr_o}, 9'h0);
  endtask

  task automatic t_window();
    step(1'b0, 1'b1, 16'h0, 4'h0, 3'b110, 3'd0);
    chk("R6 idle with write code", {strobes(), den_o, dtr_o}, 9'h0);
    step(1'b0, 1'b1, 16'h0, 4'h0, 3'b110, 3'd7);
    chk("R6 out-of-range tstate", {strobes(), den_o, dtr_o}, 9'h0);
    step(1'b0, 1'b1, 16'h0, 4'h0, 3'b011, 3'd3);
    chk("R7 halt only", {strobes(), den_o, dtr_o}, {7'b0001000, 2'b00});
  endtask

  task automatic t_status();
    bus_cycle(20'h00010, 1'b0, 3'b001, 2'b01, 1'b0);
    step(1'b0, 1'b1, 16'h0, 4'b0110, 3'b111, 3'd1);
    chk("R10 held in T1", {ie_o, seg_o}, 3'b001);
    step(1'b1, 1'b1, 16'h0, 4'b0111, 3'b111, 3'd3);
    chk("R10 held while ALE high", {ie_o, seg_o}, 3'b001);
    step(1'b0, 1'b1, 16'h0, 4'b0110, 3'b111, 3'd4);
    chk("R10 taken in window", {ie_o, seg_o}, 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_matrix();
    t_hold();
    t_window();
    t_status();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule